// File: doc/BRIEF.md
# Fine-Resolution Double-Buffered PWM Generator

This block drives one pulse-width-modulated output. An 8-bit period timer counts up to a programmable period value and wraps. A selectable prescaler sits in front of it. The duty cycle is a 10-bit number. It is compared against the timer extended by two fine bits, so the high time can be set more finely than one timer step. With divide-by-1 the fine bits are a 4-phase sub-clock counter. With the larger divides they are the upper two bits of the prescaler count.

Software programs the block through a simple register-write port. The registers are the period, the upper eight duty bits, the lower two duty bits, and a control byte holding the prescale select and an enable bit. The written duty is only a shadow copy. It moves into the active compare latch at the start of each period, so a change made mid-period never shortens or stretches the pulse in flight, whatever order the two duty fields are written in.

One timer step lasts 4·N clocks, where N is the prescale divide. A period therefore lasts 4·N·(P+1) clocks, where P is the period register.

Top module: `fine_pwm`

## Requirements
- R1: After reset, and in every cycle after one in which the enable bit reads 0, `pwm_out` is 0 and the timer and prescaler are held at zero.
- R2: While enabled, `pwm_out` rises only at a period start. A period lasts 4·N·(P+1) clocks, where P is the period register.
- R3: At each period start `pwm_out` is set. It is cleared when the 10-bit active duty equals {timer, fine bits}. With a duty D in the range 1..4P+3, the output is high for D·N clocks of each period.
- R4: Control bits [1:0] select the prescale: 0 gives N=1, 1 gives N=4, and 2 or 3 give N=16. The fine bits are prescaler count bits [1:0], [3:2] or [5:4] respectively.
- R5: An active duty of 0 keeps `pwm_out` low for the whole period.
- R6: An active duty greater than 4P+3 never matches, so `pwm_out` stays high for the whole period.
- R7: Duty writes made during a period do not change that period's high time. The shadowed duty is copied into the active latch only at the next period start.
- R8: A duty written as the upper byte (address 1) and the low field (address 2, data bits [1:0]), in either order, takes effect as the single value {upper, low} at the next period start.
- R9: A control write that changes the prescale select clears the prescaler count at once. The timer keeps its value.
- R10: The first period starts on the clock edge after the one that writes enable=1. `pwm_out` is still 0 in the cycle between those two edges.
- R11: The register addresses are: 0 for the period, 1 for the duty upper byte, 2 for the duty low field, and 3 for control (bits [1:0] prescale select, bit 2 enable). A write lands on the clock edge where `wr_en` is 1.
- R12: With the period register at FFh, all 10 duty bits are usable. A duty of 1023 at N=1 gives 1023 high clocks out of 1024.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 1 | PWM output |

## Verification
The bench runs every prescale setting against the period-length and high-time formulas. This would expose a prescaler that wraps at the wrong count or takes the fine bits from the wrong place, because the high time would not scale by N. It covers a duty of zero, a duty one past the last reachable count, and full 10-bit scale; an off-by-one compare or a set that ignores a zero duty would leave a stray pulse there or clear a long duty. Duty fields are rewritten mid-period in reverse order, which catches a design that compares against the shadow copy directly. The prescale select is switched mid-count to show that a prescaler which keeps its old count overshoots the new wrap point and stretches the period.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_PERIOD  = 2'd0;
    localparam logic [ADDR_W-1:0] A_DUTY_HI = 2'd1;
    localparam logic [ADDR_W-1:0] A_DUTY_LO = 2'd2;
    localparam logic [ADDR_W-1:0] A_CTRL    = 2'd3;
endpackage

// File: rtl/fpwm_regs.sv
module fpwm_regs
    import fpwm_pkg::*;
#(
    parameter int TMR_W  = 8,
    parameter int FINE_W = 2,
    parameter int PSEL_W = 2,
    localparam int DUTY_W = TMR_W + FINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TMR_W-1:0]  wr_data,
    output logic [TMR_W-1:0]  per,
    output logic [DUTY_W-1:0] duty_buf,
    output logic [PSEL_W-1:0] psel,
    output logic              en,
    output logic              psel_chg
);
    typedef struct packed {
        logic [TMR_W-1:0]  per;
        logic [DUTY_W-1:0] duty;
        logic [PSEL_W-1:0] psel;
        logic              en;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        psel_chg = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                A_PERIOD:  r_d.per = wr_data;
                A_DUTY_HI: r_d.duty[DUTY_W-1:FINE_W] = wr_data;
                A_DUTY_LO: r_d.duty[FINE_W-1:0] = wr_data[FINE_W-1:0];
                default: begin
                    r_d.psel = wr_data[PSEL_W-1:0];
                    r_d.en   = wr_data[PSEL_W];
                    psel_chg = (wr_data[PSEL_W-1:0] != r_q.psel);
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign per      = r_q.per;
    assign duty_buf = r_q.duty;
    assign psel     = r_q.psel;
    assign en       = r_q.en;
endmodule

// File: rtl/fpwm_timebase.sv
module fpwm_timebase #(
    parameter int TMR_W       = 8,
    parameter int FINE_W      = 2,
    parameter int PSEL_W      = 2,
    parameter int PRE_LOG_MAX = 4,
    localparam int PRE_W  = FINE_W + PRE_LOG_MAX,
    localparam int DUTY_W = TMR_W + FINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PSEL_W-1:0] psel,
    input  logic              psel_chg,
    input  logic [TMR_W-1:0]  per,
    output logic [TMR_W-1:0]  tmr,
    output logic [PRE_W-1:0]  pre,
    output logic [PRE_W-1:0]  pre_max,
    output logic              boundary,
    output logic [DUTY_W-1:0] cnt_next
);
    typedef struct packed {
        logic [TMR_W-1:0] tmr;
        logic [PRE_W-1:0] pre;
        logic             run;
    } tb_t;

    tb_t s_d, s_q;

    function automatic int unsigned div_shift(logic [PSEL_W-1:0] s);
        int unsigned v;
        v = 2 * int'(s);
        return (v > PRE_LOG_MAX) ? PRE_LOG_MAX : v;
    endfunction

    int unsigned      sh;
    logic [PRE_W:0]   lim;
    logic             step_end;
    logic             wrap;

    always_comb begin
        sh       = div_shift(psel);
        lim      = (PRE_W+1)'(1) << (FINE_W + sh);
        pre_max  = PRE_W'(lim - 1'b1);
        step_end = (s_q.pre >= pre_max);
        wrap     = step_end && (s_q.tmr >= per) && !psel_chg;
        boundary = en && (!s_q.run || wrap);

        s_d      = s_q;
        s_d.run  = en;
        if (!en || !s_q.run) begin
            s_d.tmr = '0;
            s_d.pre = '0;
        end else if (psel_chg) begin
            s_d.pre = '0;
        end else if (step_end) begin
            s_d.pre = '0;
            s_d.tmr = wrap ? '0 : s_q.tmr + 1'b1;
        end else begin
            s_d.pre = s_q.pre + 1'b1;
        end
        cnt_next = {s_d.tmr, FINE_W'(s_d.pre >> sh)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tmr = s_q.tmr;
    assign pre = s_q.pre;
endmodule

// File: rtl/fpwm_compare.sv
module fpwm_compare #(
    parameter int DUTY_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              boundary,
    input  logic [DUTY_W-1:0] cnt_next,
    input  logic [DUTY_W-1:0] duty_buf,
    output logic [DUTY_W-1:0] act,
    output logic              pwm_out
);
    typedef struct packed {
        logic [DUTY_W-1:0] act;
        logic              out;
    } cmp_t;

    cmp_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (boundary) begin
            c_d.act = duty_buf;
            c_d.out = (duty_buf != '0);
        end else if (!en) begin
            c_d.out = 1'b0;
        end else begin
            c_d.out = c_q.out && (cnt_next != c_q.act);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign act     = c_q.act;
    assign pwm_out = c_q.out;
endmodule

// File: rtl/fine_pwm.sv
module fine_pwm
    import fpwm_pkg::*;
#(
    parameter int TMR_W       = 8,
    parameter int FINE_W      = 2,
    parameter int PSEL_W      = 2,
    parameter int PRE_LOG_MAX = 4,
    localparam int PRE_W  = FINE_W + PRE_LOG_MAX,
    localparam int DUTY_W = TMR_W + FINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TMR_W-1:0]  wr_data,
    output logic              pwm_out
);
    logic [TMR_W-1:0]  per_w;
    logic [DUTY_W-1:0] duty_buf_w;
    logic [PSEL_W-1:0] psel_w;
    logic              en_w;
    logic              psel_chg_w;
    logic [TMR_W-1:0]  tmr_w;
    logic [PRE_W-1:0]  pre_w;
    logic [PRE_W-1:0]  pre_max_w;
    logic              boundary_w;
    logic [DUTY_W-1:0] cnt_next_w;
    logic [DUTY_W-1:0] act_w;

    fpwm_regs #(.TMR_W(TMR_W), .FINE_W(FINE_W), .PSEL_W(PSEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .per(per_w), .duty_buf(duty_buf_w),
        .psel(psel_w), .en(en_w), .psel_chg(psel_chg_w)
    );

    fpwm_timebase #(.TMR_W(TMR_W), .FINE_W(FINE_W), .PSEL_W(PSEL_W),
                    .PRE_LOG_MAX(PRE_LOG_MAX)) u_timebase (
        .clk(clk), .rst_n(rst_n), .en(en_w), .psel(psel_w),
        .psel_chg(psel_chg_w), .per(per_w), .tmr(tmr_w), .pre(pre_w),
        .pre_max(pre_max_w), .boundary(boundary_w), .cnt_next(cnt_next_w)
    );

    fpwm_compare #(.DUTY_W(DUTY_W)) u_compare (
        .clk(clk), .rst_n(rst_n), .en(en_w), .boundary(boundary_w),
        .cnt_next(cnt_next_w), .duty_buf(duty_buf_w), .act(act_w),
        .pwm_out(pwm_out)
    );
endmodule

// File: rtl/fpwm_checker.sv
module fpwm_checker #(
    parameter int TMR_W  = 8,
    parameter int FINE_W = 2,
    parameter int PRE_W  = 6,
    localparam int DUTY_W = TMR_W + FINE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwm_out,
    input logic              en,
    input logic [TMR_W-1:0]  tmr,
    input logic [TMR_W-1:0]  per,
    input logic [PRE_W-1:0]  pre,
    input logic [PRE_W-1:0]  pre_max,
    input logic [DUTY_W-1:0] act
);
    assert_disabled_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm_out);

    assert_rise_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> (tmr == '0 && pre == '0));

    assert_fall_on_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pwm_out) && en) |-> (tmr == act[DUTY_W-1:FINE_W]));

    assert_pre_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pre <= pre_max);

    assert_zero_duty_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act == '0) |-> !pwm_out);

    assert_long_duty_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pwm_out && act > {per, {FINE_W{1'b1}}})
            |=> (pwm_out || !en || per != $past(per)));

    assert_reload_at_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act) |-> (tmr == '0 && pre == '0));
endmodule

bind fine_pwm fpwm_checker #(.TMR_W(TMR_W), .FINE_W(FINE_W), .PRE_W(PRE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .en(en_w), .tmr(tmr_w),
    .per(per_w), .pre(pre_w), .pre_max(pre_max_w), .act(act_w)
);

// File: tb/test_fine_pwm.sv
module test_fine_pwm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pwm_out;

    always #10 clk = ~clk;

    fine_pwm i_fine_pwm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // stimulus table: period, duty, prescale select
    localparam int NV = 9;
    localparam int V_PER [NV] = '{3, 3, 3, 3, 7, 1, 1, 255, 2};
    localparam int V_DUTY[NV] = '{5, 0, 16, 15, 9, 3, 3, 1023, 12};
    localparam int V_PSEL[NV] = '{0, 0, 0, 0, 1, 2, 3, 0, 0};

    task automatic chk(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int ndiv(int s);
        return (s == 0) ? 1 : (s == 1) ? 4 : 16;
    endfunction

    function automatic int per_clks(int p, int s);
        return 4 * ndiv(s) * (p + 1);
    endfunction

    function automatic int high_clks(int p, int d, int s);
        if (d == 0) return 0;
        if (d > 4 * p + 3) return per_clks(p, s);
        return d * ndiv(s);
    endfunction

    // program, enable, and return in cycle 0 of the first period (R10, R11)
    task automatic start(int p, int d, int s);
        wr(2'd3, 8'd0);
        wr(2'd0, 8'(p));
        wr(2'd1, 8'(d >> 2));
        wr(2'd2, 8'(d & 3));
        wr(2'd3, 8'(4 | s));
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int hc;
        bit exp_seq [5];
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pwm_out == 1'b0, "R1 reset level", pwm_out, 0);

        // configured but not enabled: stays low
        wr(2'd0, 8'd3); wr(2'd1, 8'd1); wr(2'd3, 8'd0);
        hc = 0;
        for (int i = 0; i < 20; i++) begin
            if (pwm_out) hc++;
            @(negedge clk);
        end
        chk(hc == 0, "R1 disabled high count", hc, 0);

        // R10: first period begins the edge after the enable write
        wr(2'd3, 8'd4);
        chk(pwm_out == 1'b0, "R10 low in cycle after enable write", pwm_out, 0);
        @(negedge clk);
        chk(pwm_out == 1'b1, "R10 high at first period start", pwm_out, 1);

        // table walk: R2 R3 R4 R5 R6 R12
        for (int v = 0; v < NV; v++) begin
            int p, d, s, t, h;
            string tag;
            p = V_PER[v]; d = V_DUTY[v]; s = V_PSEL[v];
            t = per_clks(p, s);
            h = high_clks(p, d, s);
            tag = (d == 0) ? "R5" : (d > 4 * p + 3) ? "R6" : (p == 255) ? "R12" : (s != 0) ? "R4" : "R3";
            start(p, d, s);
            chk(pwm_out == (d != 0), $sformatf("R2 level at period start v=%0d", v), pwm_out, int'(d != 0));
            hc = 0;
            for (int i = 0; i < 2 * t; i++) begin
                if (i == t) chk(pwm_out == (d != 0), $sformatf("R2 level at second start v=%0d", v), pwm_out, int'(d != 0));
                if (pwm_out) hc++;
                @(negedge clk);
            end
            chk(hc == 2 * h, $sformatf("%s high clocks over two periods v=%0d", tag, v), hc, 2 * h);
        end

        // R7 / R8: mid-period duty change, low field written first
        start(3, 5, 0);
        wr(2'd2, 8'd0);
        wr(2'd1, 8'd2);
        hc = 0;
        for (int i = 0; i < 14; i++) begin
            if (pwm_out) hc++;
            @(negedge clk);
        end
        chk(hc == 3, "R7 current period keeps old duty", hc, 3);
        hc = 0;
        for (int i = 0; i < 16; i++) begin
            if (pwm_out) hc++;
            @(negedge clk);
        end
        chk(hc == 8, "R8 new duty after boundary", hc, 8);

        // R9: prescale change clears the prescaler count
        start(0, 2, 2);
        repeat (10) @(negedge clk);
        wr(2'd3, 8'd4);
        exp_seq = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
        for (int i = 0; i < 5; i++) begin
            chk(pwm_out == exp_seq[i], $sformatf("R9 output after select change i=%0d", i), pwm_out, int'(exp_seq[i]));
            @(negedge clk);
        end

        // R1: disable while running
        start(3, 15, 0);
        wr(2'd3, 8'd0);
        @(negedge clk);
        hc = 0;
        for (int i = 0; i < 20; i++) begin
            if (pwm_out) hc++;
            @(negedge clk);
        end
        chk(hc == 0, "R1 low after disable", hc, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule